// File: doc/BRIEF.md
# Banked Vector Register File

This block is the register storage behind a four-lane fused multiply-add datapath. It holds 128 registers of 64 bits. Instead of one heavily multi-ported array, the storage is split into four banks. Each bank is a plain memory with a single read port and a single write port. The low two bits of a register number pick the bank and the upper five bits pick the row inside it. As a result, four consecutively numbered registers always sit in four different banks and can be read together in one cycle.

Each cycle the issuing pipeline may present up to four reads and four writes, one of each per lane. Each request is a valid bit and a 7-bit register number, and a write also carries 64 bits of data. Requests that fall in different banks are served at once. Requests that collide on a bank are taken one per cycle, lowest lane first. While any accepted request is still waiting, the block raises a stall and ignores its request inputs. Read data comes back one cycle after a request is served, on the output slot of the lane that asked for it.

Top module: `vrf_banked`

## Requirements
- R1: Every register other than 0 stores a 64-bit value written to it, and a later read of that register returns the value.
- R2: A register's bank is its register number bits [1:0] and its row is bits [6:2]. Requests that all fall in distinct banks are served in the cycle they are accepted, and stall_o stays low.
- R3: Reads that target the same bank are served one per cycle in ascending lane order, starting in the cycle they are accepted.
- R4: Writes that target the same bank are committed one per cycle in ascending lane order. When several lanes write the same register, the highest such lane's data is what remains.
- R5: stall_o rises in the cycle after the requests are accepted if any of them could not be served, and stays high until the last one is served. For a largest same-bank group of size k, stall_o is high for k-1 cycles and never for more than three in a row.
- R6: While stall_o is high, all request inputs are ignored, and stall_o is low out of reset.
- R7: A read served in a given cycle sets rd_vld_o of its lane for exactly the next cycle. The data appears on that lane's 64-bit slot, lane l at bits [64*l+63:64*l]. With no reads pending, rd_vld_o is all zero.
- R8: A read and a write of the same register that are served in the same cycle return the value held before the write. A read served in a later cycle returns the new value.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: A read and a write that target the same bank in the same cycle do not conflict and cause no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_vld_i | input | 4 | Per-lane read request valid |
| rd_addr_i | input | 28 | Per-lane 7-bit read register number, lane l at bits [7l+6:7l] |
| wr_vld_i | input | 4 | Per-lane write request valid |
| wr_addr_i | input | 28 | Per-lane 7-bit write register number, lane l at bits [7l+6:7l] |
| wr_data_i | input | 256 | Per-lane 64-bit write data, lane l at bits [64l+63:64l] |
| stall_o | output | 1 | High while accepted requests are still waiting for their bank |
| rd_vld_o | output | 4 | Per-lane read data valid |
| rd_data_o | output | 256 | Per-lane read data, lane l at bits [64l+63:64l] |

## Verification
Every read result is due in the cycle that follows the edge where its bank serves it. A lane that ranks r-th among the same-bank requests of one issue is served at the r-th edge after acceptance, so its data shows up r cycles later than a conflict-free read. The bench computes each lane's rank and the largest group size from the register numbers it drives. After each edge it then samples at the falling clock edge and checks each lane's valid bit and data, and whether stall_o is still high. A write is checked by a read issued no earlier than the cycle after the write was committed, except in the deliberate same-cycle case, which must return the old value.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  // One-hot of the lowest set bit, zero when none set.
  function automatic logic [31:0] lowest_one(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction
endpackage

// File: rtl/vrf_prio_arb.sv
module vrf_prio_arb #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [31:0] wide;
  always_comb begin
    wide  = vrf_pkg::lowest_one(32'(req_i));
    gnt_o = wide[N-1:0];
  end
endmodule

// File: rtl/vrf_bank.sv
module vrf_bank #(
  parameter int unsigned ROWS   = 32,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic [ROW_W-1:0]  rd_row_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem [ROWS];
  logic [DATA_W-1:0] rd_q;

  // Read samples before the write lands: old data on a same-row collision.
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_q <= mem[rd_row_i];
    if (wr_en_i) mem[wr_row_i] <= wr_data_i;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/vrf_banked.sv
module vrf_banked #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BANKS  = 4,
  parameter int unsigned REGS   = 128,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned ADDR_W = $clog2(REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [LANES-1:0]          rd_vld_i,
  input  logic [LANES*ADDR_W-1:0]   rd_addr_i,
  input  logic [LANES-1:0]          wr_vld_i,
  input  logic [LANES*ADDR_W-1:0]   wr_addr_i,
  input  logic [LANES*DATA_W-1:0]   wr_data_i,
  output logic                      stall_o,
  output logic [LANES-1:0]          rd_vld_o,
  output logic [LANES*DATA_W-1:0]   rd_data_o
);
  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned ROW_W  = ADDR_W - BANK_W;
  localparam int unsigned ROWS   = REGS / BANKS;

  logic [LANES-1:0]        rd_pend_q, wr_pend_q;
  logic [LANES*ADDR_W-1:0] rd_addr_q, wr_addr_q;
  logic [LANES*DATA_W-1:0] wr_data_q;

  logic [LANES-1:0]        rd_act, wr_act, rd_served, wr_served;
  logic [LANES*ADDR_W-1:0] rd_addr_act, wr_addr_act;
  logic [LANES*DATA_W-1:0] wr_data_act;

  logic [LANES-1:0]  rd_gnt_b    [BANKS];
  logic [LANES-1:0]  wr_gnt_b    [BANKS];
  logic [LANES-1:0]  bank_lane_q [BANKS];
  logic              bank_zero_q [BANKS];
  logic [DATA_W-1:0] bank_rdata  [BANKS];

  assign stall_o = |{rd_pend_q, wr_pend_q};

  // While stalled, serve the latched leftovers; otherwise the fresh inputs.
  always_comb begin
    rd_act      = stall_o ? rd_pend_q : rd_vld_i;
    wr_act      = stall_o ? wr_pend_q : wr_vld_i;
    rd_addr_act = stall_o ? rd_addr_q : rd_addr_i;
    wr_addr_act = stall_o ? wr_addr_q : wr_addr_i;
    wr_data_act = stall_o ? wr_data_q : wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else if (!stall_o) begin
      rd_addr_q <= rd_addr_i;
      wr_addr_q <= wr_addr_i;
      wr_data_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= '0;
      wr_pend_q <= '0;
    end else begin
      rd_pend_q <= rd_act & ~rd_served;
      wr_pend_q <= wr_act & ~wr_served;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LANES-1:0]  rd_req, wr_req;
    logic [ADDR_W-1:0] rd_sel, wr_sel;
    logic [DATA_W-1:0] wr_dat;
    logic              wr_en;

    always_comb begin
      for (int l = 0; l < LANES; l++) begin
        rd_req[l] = rd_act[l] &&
                    (rd_addr_act[l*ADDR_W +: BANK_W] == BANK_W'(b));
        wr_req[l] = wr_act[l] &&
                    (wr_addr_act[l*ADDR_W +: BANK_W] == BANK_W'(b));
      end
    end

    vrf_prio_arb #(.N(LANES)) u_rd_arb (.req_i(rd_req), .gnt_o(rd_gnt_b[b]));
    vrf_prio_arb #(.N(LANES)) u_wr_arb (.req_i(wr_req), .gnt_o(wr_gnt_b[b]));

    always_comb begin
      rd_sel = '0;
      wr_sel = '0;
      wr_dat = '0;
      for (int l = 0; l < LANES; l++) begin
        if (rd_gnt_b[b][l]) rd_sel = rd_addr_act[l*ADDR_W +: ADDR_W];
        if (wr_gnt_b[b][l]) begin
          wr_sel = wr_addr_act[l*ADDR_W +: ADDR_W];
          wr_dat = wr_data_act[l*DATA_W +: DATA_W];
        end
      end
      wr_en = (|wr_gnt_b[b]) && (wr_sel != '0);
    end

    vrf_bank #(.ROWS(ROWS), .DATA_W(DATA_W)) u_bank (
      .clk_i     (clk_i),
      .rd_en_i   (|rd_gnt_b[b]),
      .rd_row_i  (rd_sel[ADDR_W-1:BANK_W]),
      .rd_data_o (bank_rdata[b]),
      .wr_en_i   (wr_en),
      .wr_row_i  (wr_sel[ADDR_W-1:BANK_W]),
      .wr_data_i (wr_dat)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bank_lane_q[b] <= '0;
        bank_zero_q[b] <= 1'b0;
      end else begin
        bank_lane_q[b] <= rd_gnt_b[b];
        bank_zero_q[b] <= (rd_sel == '0);
      end
    end
  end

  always_comb begin
    rd_served = '0;
    wr_served = '0;
    for (int b = 0; b < BANKS; b++) begin
      rd_served |= rd_gnt_b[b];
      wr_served |= wr_gnt_b[b];
    end
  end

  // Return crossbar: each lane is served by at most one bank per cycle.
  always_comb begin
    rd_vld_o  = '0;
    rd_data_o = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int b = 0; b < BANKS; b++) begin
        if (bank_lane_q[b][l]) begin
          rd_vld_o[l] = 1'b1;
          rd_data_o[l*DATA_W +: DATA_W] = bank_zero_q[b] ? '0 : bank_rdata[b];
        end
      end
    end
  end

  logic unused_rows;
  assign unused_rows = ^ROW_W;
endmodule

// File: rtl/vrf_banked_checker.sv
module vrf_banked_checker #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BANKS  = 4,
  parameter int unsigned REGS   = 128,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned ADDR_W = $clog2(REGS)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [LANES-1:0]        rd_vld_i,
  input logic [LANES*ADDR_W-1:0] rd_addr_i,
  input logic [LANES-1:0]        wr_vld_i,
  input logic [LANES*ADDR_W-1:0] wr_addr_i,
  input logic                    stall_o,
  input logic [LANES-1:0]        rd_vld_o,
  input logic [DATA_W-1:0]       lane0_data_i
);
  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned CNT_W  = $clog2(LANES) + 1;

  logic             clash;
  logic [CNT_W-1:0] stall_cnt;

  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++) begin
        if (rd_vld_i[i] && rd_vld_i[j] &&
            rd_addr_i[i*ADDR_W +: BANK_W] == rd_addr_i[j*ADDR_W +: BANK_W])
          clash = 1'b1;
        if (wr_vld_i[i] && wr_vld_i[j] &&
            wr_addr_i[i*ADDR_W +: BANK_W] == wr_addr_i[j*ADDR_W +: BANK_W])
          clash = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_cnt <= '0;
    else         stall_cnt <= stall_o ? stall_cnt + 1'b1 : '0;
  end

  assert_distinct_banks_no_stall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !clash) |=> !stall_o);

  assert_stall_bounded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (int'(stall_cnt) < int'(LANES) - 1));

  assert_lane0_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && rd_vld_i[0]) |=> rd_vld_o[0]);

  assert_idle_no_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && rd_vld_i == '0) |=> rd_vld_o == '0);

  assert_reg0_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && rd_vld_i[0] && rd_addr_i[ADDR_W-1:0] == '0) |=> lane0_data_i == '0);
endmodule

bind vrf_banked vrf_banked_checker #(
  .LANES(LANES), .BANKS(BANKS), .REGS(REGS), .DATA_W(DATA_W)
) u_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_vld_i     (rd_vld_i),
  .rd_addr_i    (rd_addr_i),
  .wr_vld_i     (wr_vld_i),
  .wr_addr_i    (wr_addr_i),
  .stall_o      (stall_o),
  .rd_vld_o     (rd_vld_o),
  .lane0_data_i (rd_data_o[DATA_W-1:0])
);

// File: tb/vrf_banked_test.sv
module vrf_banked_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0, rst_ni = 0;
  logic [3:0]   rd_vld = '0, wr_vld = '0;
  logic [27:0]  rd_addr = '0, wr_addr = '0;
  logic [255:0] wr_data = '0;
  logic         stall;
  logic [3:0]   rd_vld_o;
  logic [255:0] rd_data_o;

  int n_checks = 0, n_errs = 0;
  logic [63:0] model [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  vrf_banked uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_vld_i(rd_vld), .rd_addr_i(rd_addr),
    .wr_vld_i(wr_vld), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .stall_o(stall), .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o)
  );

  function automatic logic [63:0] val(input int a, input int s);
    return {8'(a), 8'(s), 16'(a * 37 + s), (32'(a) * 32'h9E3779B9) ^ 32'(s)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue reads; lane l is served at edge rank(l) after acceptance.
  task automatic run_reads(input logic [3:0] v, input logic [27:0] a, input string req);
    int rank [4];
    int cnt [4];
    int mx;
    mx = 0;
    for (int b = 0; b < 4; b++) cnt[b] = 0;
    for (int l = 0; l < 4; l++) begin
      rank[l] = 0;
      if (v[l]) begin
        rank[l] = cnt[a[l*7 +: 2]];
        cnt[a[l*7 +: 2]]++;
        if (cnt[a[l*7 +: 2]] > mx) mx = cnt[a[l*7 +: 2]];
      end
    end
    @(negedge clk);
    rd_vld = v; rd_addr = a;
    for (int c = 0; c < mx; c++) begin
      @(negedge clk);
      rd_vld = '0;
      for (int l = 0; l < 4; l++) begin
        logic e;
        e = v[l] && rank[l] == c;
        chk({req, " R3 lane valid order"}, 64'(rd_vld_o[l]), 64'(e));
        if (e) chk({req, " R7 lane data"}, rd_data_o[l*64 +: 64], model[a[l*7 +: 7]]);
      end
      chk({req, " R5 stall"}, 64'(stall), 64'(c < mx - 1));
    end
  endtask

  task automatic run_writes(input logic [3:0] v, input logic [27:0] a,
                            input logic [255:0] d, input string req);
    int cnt [4];
    int mx;
    mx = 0;
    for (int b = 0; b < 4; b++) cnt[b] = 0;
    for (int l = 0; l < 4; l++)
      if (v[l]) begin
        cnt[a[l*7 +: 2]]++;
        if (cnt[a[l*7 +: 2]] > mx) mx = cnt[a[l*7 +: 2]];
        if (a[l*7 +: 7] != 0) model[a[l*7 +: 7]] = d[l*64 +: 64];
      end
    @(negedge clk);
    wr_vld = v; wr_addr = a; wr_data = d;
    for (int c = 0; c < mx; c++) begin
      @(negedge clk);
      wr_vld = '0;
      chk({req, " R5 write stall"}, 64'(stall), 64'(c < mx - 1));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [27:0] a;
    logic [255:0] d;
    for (int i = 0; i < 128; i++) model[i] = '0;
    #(CLK_PERIOD * 3);
    chk("R6 reset stall", 64'(stall), 64'd0);
    chk("R7 reset valid", 64'(rd_vld_o), 64'd0);
    @(negedge clk); rst_ni = 1;

    // R1 R2 R9: fill every register with consecutive numbers, no conflicts.
    for (int base = 0; base < 128; base += 4) begin
      for (int l = 0; l < 4; l++) begin
        a[l*7 +: 7] = 7'(base + l);
        d[l*64 +: 64] = val(base + l, 1);
      end
      run_writes(4'hF, a, d, "R2 fill");
    end
    for (int base = 0; base < 128; base += 4) begin
      for (int l = 0; l < 4; l++) a[l*7 +: 7] = 7'(base + l);
      run_reads(4'hF, a, "R1 R9 readback");
    end

    // R3 R5: every bank assignment of four reads.
    for (int p = 0; p < 256; p++) begin
      for (int l = 0; l < 4; l++)
        a[l*7 +: 7] = 7'(((p >> (2*l)) & 3) + 4 * (1 + l + 4 * (p % 7)));
      run_reads(4'hF, a, "R3 sweep");
    end
    run_reads(4'b1010, {7'd9, 7'd0, 7'd5, 7'd0}, "R3 sparse");

    // R4: four writes to bank 1, then same-register writes from lanes 0 and 2.
    for (int l = 0; l < 4; l++) d[l*64 +: 64] = val(l, 2);
    run_writes(4'hF, {7'd13, 7'd9, 7'd5, 7'd1}, d, "R4 bank clash");
    run_reads(4'hF, {7'd14, 7'd13, 7'd9, 7'd1}, "R4 readback");
    chk("R4 model lane3", model[13], val(3, 2));
    run_writes(4'b0101, {7'd0, 7'd30, 7'd0, 7'd30}, d, "R4 same reg");
    chk("R4 higher lane wins", model[30], val(2, 2));
    run_reads(4'b0001, {21'd0, 7'd30}, "R4 same reg read");

    // R6: requests during stall must be ignored.
    @(negedge clk);
    rd_vld = 4'hF; rd_addr = {7'd16, 7'd12, 7'd8, 7'd4};
    @(negedge clk);
    chk("R5 stall raised", 64'(stall), 64'd1);
    rd_vld = 4'b0001; rd_addr = {21'd0, 7'd33};
    wr_vld = 4'b0010; wr_addr = {14'd0, 7'd33, 7'd0}; wr_data = {128'd0, val(99, 9), 64'd0};
    @(negedge clk);
    rd_vld = '0; wr_vld = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 stall cleared", 64'(stall), 64'd0);
    chk("R6 ignored read", 64'(rd_vld_o), 64'b1000);
    run_reads(4'b0001, {21'd0, 7'd33}, "R6 ignored write");

    // R8: same-cycle read and write of register 40 return the old value.
    @(negedge clk);
    rd_vld = 4'b0001; rd_addr = {21'd0, 7'd40};
    wr_vld = 4'b0001; wr_addr = {21'd0, 7'd40}; wr_data = {192'd0, val(40, 5)};
    @(negedge clk);
    wr_vld = '0;
    chk("R8 old value", rd_data_o[63:0], model[40]);
    chk("R10 no stall", 64'(stall), 64'd0);
    model[40] = val(40, 5);
    @(negedge clk);
    rd_vld = '0;
    chk("R8 new value", rd_data_o[63:0], val(40, 5));

    // R9: write to register 0 discarded.
    run_writes(4'b0001, 28'd0, {192'd0, 64'hDEAD_BEEF_0000_0001}, "R9 write zero");
    run_reads(4'b0001, 28'd0, "R9 read zero");
    chk("R9 zero data", rd_data_o[63:0], 64'd0);

    // R10: read and write to bank 0 together.
    @(negedge clk);
    rd_vld = 4'b0001; rd_addr = {21'd0, 7'd4};
    wr_vld = 4'b0010; wr_addr = {14'd0, 7'd8, 7'd0}; wr_data = {128'd0, val(8, 7), 64'd0};
    @(negedge clk);
    rd_vld = '0; wr_vld = '0;
    chk("R10 rw same bank stall", 64'(stall), 64'd0);
    chk("R10 read data", rd_data_o[63:0], model[4]);
    model[8] = val(8, 7);
    run_reads(4'b0100, {7'd0, 7'd8, 14'd0}, "R10 write landed");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule